// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

A purely combinational bitfield unit for a 64-bit integer datapath. In the same cycle it can pull a field out of a source word and right-align it, zero a field inside a word, or overwrite a field of a word with the low bits of an insert value. The field's position and width come from one packed control word that would normally sit in a register, so the unit serves the case where offset and width are known only at run time.

The control word packs the field width minus one in its low six bits and the bit offset in the next six bits. All higher control bits are ignored. An operation select picks the function. The unused select code produces a zero result and raises an illegal flag.

Top module: `bitfield_unit`

## Requirements
- R1: With op_i = 2'b00 (extract), result_o equals bits [offset+count : offset] of src_i, moved down to bit 0. All other result bits are zero.
- R2: A count field of 0 selects a 1-bit field. In general the field is count+1 bits wide.
- R3: A count of 63 selects a full 64-bit mask with no overflow. Extract with offset 0 and count 63 returns src_i unchanged.
- R4: With op_i = 2'b01 (clear), result_o equals src_i with the field bits forced to zero and every other bit kept.
- R5: With op_i = 2'b10 (write), result_o equals src_i outside the field. Inside the field it holds the low count+1 bits of ins_val_i, shifted up by offset.
- R6: During write, the bits of ins_val_i above bit count have no effect on result_o.
- R7: Field bits that would land above bit 63 are dropped. Clear and write never alter src_i below the offset. Extract returns zero in positions whose source bit would lie above bit 63.
- R8: The control word fields are count = ctrl_i[5:0] and offset = ctrl_i[11:6]. Bits ctrl_i[63:12] have no effect on any output.
- R9: op_i = 2'b11 drives result_o to zero and illegal_o to 1. The other three codes hold illegal_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 | Source word |
| ctrl_i | input | 64 | Packed control word: count in [5:0], offset in [11:6] |
| ins_val_i | input | 64 | Value whose low bits are written into the field |
| op_i | input | 2 | Operation: 00 extract, 01 clear, 10 write, 11 illegal |
| result_o | output | 64 | Result word |
| illegal_o | output | 1 | High for the unused operation code |

## Verification
Mask saturation at count 63 and truncation of the field past bit 63 can occur on the same input. Any nonzero offset combined with a wide count triggers both. The bench sweeps every offset against every count for all three operations, so each such pairing is covered. It fills the ignored upper control bits and the insert value's spare bits with random data. Each result is judged against a bit-by-bit reference that decides field membership per position, without forming any shifted mask.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [1:0] {
    BFU_EXTRACT = 2'b00,
    BFU_CLEAR   = 2'b01,
    BFU_WRITE   = 2'b10,
    BFU_BAD     = 2'b11
  } bfu_op_e;

  // Low-ones mask of (cnt+1) bits, formed by comparison so that a full
  // width never needs a shift by the word size.
  function automatic logic [63:0] low_ones(input logic [5:0] cnt);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) begin
      m[i] = (i <= int'(cnt));
    end
    return m;
  endfunction

  // Place a right-aligned mask at the offset; bits past the top fall off.
  function automatic logic [63:0] place_mask(input logic [63:0] m,
                                             input logic [5:0]  off);
    return m << off;
  endfunction

endpackage

// File: rtl/bfu_ctrl_decode.sv
module bfu_ctrl_decode #(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 64,
  localparam int FW = $clog2(DATA_W)
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [FW-1:0]     count_o,
  output logic [FW-1:0]     offset_o
);

  assign count_o  = ctrl_i[FW-1:0];
  assign offset_o = ctrl_i[2*FW-1:FW];

  logic unused_hi;
  assign unused_hi = ^ctrl_i[CTRL_W-1:2*FW];

endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int DATA_W = 64,
  localparam int FW = $clog2(DATA_W)
) (
  input  logic [FW-1:0]     count_i,
  input  logic [FW-1:0]     offset_i,
  output logic [DATA_W-1:0] low_mask_o,
  output logic [DATA_W-1:0] field_mask_o
);

  for (genvar g = 0; g < DATA_W; g++) begin : g_low
    assign low_mask_o[g] = (g <= int'(count_i));
  end

  assign field_mask_o = low_mask_o << offset_i;

  always_comb begin
    // R2
    mask_width_chk: assert ($countones(low_mask_o) == int'(count_i) + 1)
      else $error("low mask width wrong");
    // R7
    field_trunc_chk: assert ($countones(field_mask_o) <= int'(count_i) + 1)
      else $error("placed mask grew");
    // R3
    full_mask_chk: assert (!(&count_i) || (&low_mask_o))
      else $error("count max did not give all ones");
  end

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 64,
  localparam int FW = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] ins_val_i,
  input  logic [1:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  import bfu_pkg::*;

  logic [FW-1:0]     count_w, offset_w;
  logic [DATA_W-1:0] low_mask_w, field_mask_w;
  logic [DATA_W-1:0] extract_w, cleared_w, written_w;
  bfu_op_e           op_w;

  assign op_w = bfu_op_e'(op_i);

  bfu_ctrl_decode #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_dec (
    .ctrl_i  (ctrl_i),
    .count_o (count_w),
    .offset_o(offset_w)
  );

  bfu_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .count_i     (count_w),
    .offset_i    (offset_w),
    .low_mask_o  (low_mask_w),
    .field_mask_o(field_mask_w)
  );

  assign extract_w = (src_i >> offset_w) & low_mask_w;
  assign cleared_w = src_i & ~field_mask_w;
  assign written_w = cleared_w | ((ins_val_i & low_mask_w) << offset_w);

  always_comb begin
    illegal_o = 1'b0;
    unique case (op_w)
      BFU_EXTRACT: result_o = extract_w;
      BFU_CLEAR:   result_o = cleared_w;
      BFU_WRITE:   result_o = written_w;
      default: begin
        result_o  = '0;
        illegal_o = 1'b1;
      end
    endcase
  end

  always_comb begin
    // R1
    extract_width_chk: assert (op_w != BFU_EXTRACT || (result_o & ~low_mask_w) == '0)
      else $error("extract has bits above field");
    // R4
    clear_subset_chk: assert (op_w != BFU_CLEAR || (result_o & ~src_i) == '0)
      else $error("clear set a bit");
    // R5
    write_outside_chk: assert (op_w != BFU_WRITE || ((result_o ^ src_i) & ~field_mask_w) == '0)
      else $error("write touched outside field");
    // R9
    illegal_zero_chk: assert (!illegal_o || result_o == '0)
      else $error("illegal op gave nonzero result");
  end

endmodule

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src, ctrl, val, res;
  logic [1:0]  op;
  logic        ill;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  bitfield_unit u_bitfield_unit (
    .src_i(src), .ctrl_i(ctrl), .ins_val_i(val), .op_i(op),
    .result_o(res), .illegal_o(ill)
  );

  // Per-bit reference: a bit belongs to the field when off <= i <= off+cnt.
  function automatic logic [64:0] model(input logic [1:0] o, input logic [63:0] s,
                                        input logic [63:0] c, input logic [63:0] v);
    int cnt, off;
    logic [63:0] r;
    cnt = int'(c[5:0]);
    off = int'(c[11:6]);
    r = '0;
    if (o == 2'b11) return {1'b1, 64'd0};
    for (int i = 0; i < 64; i++) begin
      if (o == 2'b00)
        r[i] = (i <= cnt && i + off < 64) ? s[i+off] : 1'b0;
      else if (i >= off && i <= off + cnt)
        r[i] = (o == 2'b10) ? v[i-off] : 1'b0;
      else
        r[i] = s[i];
    end
    return {1'b0, r};
  endfunction

  task automatic apply(input logic [1:0] o, input logic [63:0] s,
                       input logic [63:0] c, input logic [63:0] v, input string tag);
    logic [64:0] exp;
    @(negedge clk);
    op = o; src = s; ctrl = c; val = v;
    #2;
    exp = model(o, s, c, v);
    n_cmp++;
    if ({ill, res} !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d ctrl=%h src=%h val=%h got=%b_%h exp=%b_%h",
               tag, o, c, s, v, ill, res, exp[64], exp[63:0]);
    end
  endtask

  task automatic check_eq(input logic [63:0] got, input logic [63:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int off, input int cnt);
    return {$urandom, $urandom} & ~64'hFFF | 64'(off << 6) | 64'(cnt);
  endfunction

  initial begin
    logic [63:0] s, v, r1;
    op = 2'b00; src = '0; ctrl = '0; val = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #2;
    // reset-state inputs: extract of zero gives zero, not illegal (R9)
    check_eq({63'd0, ill}, 64'd0, "R9 idle illegal");
    check_eq(res, 64'd0, "R1 idle result");

    // R2: count 0 is one bit
    apply(2'b00, 64'h8, 64'(3 << 6), '0, "R2 one-bit extract");
    check_eq(res, 64'd1, "R2 one-bit value");
    // R3: count 63 offset 0 returns source
    s = 64'hDEAD_BEEF_0123_4567;
    apply(2'b00, s, 64'd63, '0, "R3 full extract");
    check_eq(res, s, "R3 identity");
    apply(2'b01, s, 64'd63, '0, "R3 full clear");
    check_eq(res, 64'd0, "R3 full clear zero");
    // R7: field runs past top
    apply(2'b00, 64'hF000_0000_0000_0000, 64'((60 << 6) | 20), '0, "R7 extract past top");
    check_eq(res, 64'hF, "R7 truncated extract");
    apply(2'b10, 64'd0, 64'((62 << 6) | 10), 64'hFFFF, "R7 write past top");
    check_eq(res, 64'hC000_0000_0000_0000, "R7 truncated write");
    // R6: spare value bits ignored
    apply(2'b10, 64'd0, 64'((4 << 6) | 3), 64'hFFFF_FFFF_FFFF_FFF5, "R6 write spare bits");
    check_eq(res, 64'h50, "R6 only low bits used");
    // R8: upper control bits ignored
    s = 64'h0123_4567_89AB_CDEF;
    apply(2'b00, s, 64'((8 << 6) | 7), '0, "R8 clean ctrl");
    r1 = res;
    apply(2'b00, s, 64'hFFFF_FFFF_FFFF_F000 | 64'((8 << 6) | 7), '0, "R8 dirty ctrl");
    check_eq(res, r1, "R8 upper bits no effect");
    check_eq(res, 64'hCD, "R8 field position");
    // R9: illegal code
    apply(2'b11, s, 64'd5, s, "R9 illegal op");

    // Exhaustive offset x count sweep, all three ops (R1 R4 R5 R7 R8)
    for (int o = 0; o < 64; o++) begin
      for (int c = 0; c < 64; c++) begin
        s = {$urandom, $urandom};
        v = {$urandom, $urandom};
        apply(2'b00, s, mk(o, c), v, "R1 sweep extract");
        apply(2'b01, s, mk(o, c), v, "R4 sweep clear");
        apply(2'b10, s, mk(o, c), v, "R5 sweep write");
      end
    end
    for (int k = 0; k < 32; k++)
      apply(2'b11, {$urandom, $urandom}, mk(k, 63 - k), {$urandom, $urandom}, "R9 sweep illegal");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule